// File: doc/BRIEF.md
# Nonvolatile Memory Programming Command Controller

This block stands between an external programming port and a small nonvolatile memory model held in registers: a byte array split into pages, plus one page-sized staging buffer. The port reaches the block over two paths. A control path writes byte registers chosen by `ctl_sel`. A memory path carries byte reads and byte writes at a full byte address. Every memory-path access stays inert until an unlock handshake has finished. After that, the 7-bit command register decides what a memory access or an execute write actually does.

Each command has three attributes: a launch source (an execute bit, a memory read or a memory write), a guard requirement, and whether it starts a busy period. A busy period lasts `BUSY_CYCLES` clocks. During it, reads are blocked and new launches are refused. The operation takes effect on the last busy clock. Two lock bits restrict the legal commands.

Control selectors: 0 signature, 1 key, 2 command (`ctl_wdata[6:0]`), 3 execute (`ctl_wdata[0]`), 4 lock (`ctl_wdata[1:0]`), 5 guard. Command codes:

| Code | Operation | Launched by | Guarded | Busy |
|------|-----------|-------------|---------|------|
| 0x00 | none | none | no | no |
| 0x40 | chip erase | execute | yes | yes |
| 0x43 | read array | memory read | no | no |
| 0x23 | load buffer | memory write | no | no |
| 0x26 | erase buffer | execute | yes | yes |
| 0x2B | erase page | memory write | no | yes |
| 0x2E | write page | memory write | no | yes |
| 0x78 | check stub | execute | no | yes |

Access FSM (`nvmprog_unlock`) has three states:
- `UL_CLOSED` moves to `UL_SIG_SEEN` when the signature register is written with 0x59.
- `UL_SIG_SEEN` moves to `UL_OPEN` when the key register is written with `KEY`. A wrong key moves it back to `UL_CLOSED`.
- From any state, writing the signature register with a value other than 0x59 returns the FSM to `UL_CLOSED`.

Command FSM (`nvmprog_ctrl`) has two states:
- `ST_IDLE` moves to `ST_BUSY` when a busy command launches.
- `ST_BUSY` moves back to `ST_IDLE` on its last counted clock. That clock is the "finish" transition, where the stored operation is applied.

Top module: `nvmprog_ctrl`

## Requirements
- R1: After reset, `nvm_en`, `busy`, `lock_bits` and `rd_valid` are 0, and every array and buffer byte is 0xFF.
- R2: `nvm_en` becomes 1 only when a key write equal to `KEY` directly follows a signature write of 0x59. A wrong key, or a signature value other than 0x59, leaves or returns `nvm_en` at 0.
- R3: While `nvm_en` is 0, control writes to selectors 2 to 5 are ignored, no command launches, and reads are blocked.
- R4: Every `mem_rd` produces `rd_valid` on the next cycle. When the block is open, idle, holds command 0x43 and is not fully locked, the response carries the array byte at the full byte address with `rd_blocked`=0. Otherwise it carries 0xFF with `rd_blocked`=1.
- R5: With command 0x23, a `mem_wr` stores `mem_wdata` into buffer slot `mem_addr[log2(PAGE_BYTES)-1:0]`, ignores the high address bits, and starts no busy period.
- R6: With command 0x2E (write page) or 0x2B (erase page), a `mem_wr` acts on page `mem_addr[ADDR_W-1:log2(PAGE_BYTES)]`. Write page copies the buffer into that page; erase page fills it with 0xFF.
- R7: A busy command raises `busy` on the cycle after its trigger and holds it for exactly `BUSY_CYCLES` cycles.
- R8: While `busy` is 1, reads are blocked and launches are ignored. Command register writes are still accepted.
- R9: An execute write with bit 0 set launches only commands 0x40, 0x26 and 0x78. For any other command, or with bit 0 clear, it has no effect.
- R10: Guarded commands 0x40 and 0x26 launch only if the control write immediately before the execute write was a guard write of 0xA5. Any other control write disarms the guard.
- R11: Lock writes, accepted while open and idle, OR `ctl_wdata[1:0]` into `lock_bits` (bit 0 read lock, bit 1 write lock). With both bits set, only 0x40 and 0x78 launch. A single bit restricts nothing.
- R12: Chip erase fills the array and the buffer with 0xFF and clears `lock_bits` when it completes.
- R13: Erase buffer (0x26) fills every buffer byte with 0xFF.
- R14: The check stub (0x78) runs a busy period and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 3 | Control register selector |
| ctl_wdata | input | 8 | Control write data |
| mem_rd | input | 1 | Memory read access |
| mem_wr | input | 1 | Memory write access |
| mem_addr | input | ADDR_W | Byte address of the memory access |
| mem_wdata | input | 8 | Memory write data |
| nvm_en | output | 1 | Interface open |
| busy | output | 1 | Busy period in progress |
| lock_bits | output | 2 | Lock state (bit 0 read, bit 1 write) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |
| rd_blocked | output | 1 | Read response was refused |

## Verification
Control-register effects on `nvm_en`, `lock_bits` and `busy`, and read responses, all appear one clock after the access that caused them. Array changes made by busy commands can only be seen after `busy` falls, `BUSY_CYCLES` clocks after the trigger. The bench drives each access on a falling edge for exactly one cycle and samples level outputs on the following falling edge. A scoreboard queue receives each read's expected response when the read is issued, and the monitor pops the queue on the falling edge where `rd_valid` is high. Busy length is measured by counting falling edges with `busy` high, starting right after the trigger.

// File: rtl/nvmprog_pkg.sv
package nvmprog_pkg;

    localparam logic [6:0] CMD_NOP        = 7'h00;
    localparam logic [6:0] CMD_CHIP_ERASE = 7'h40;
    localparam logic [6:0] CMD_READ       = 7'h43;
    localparam logic [6:0] CMD_LOAD_BUF   = 7'h23;
    localparam logic [6:0] CMD_ERASE_BUF  = 7'h26;
    localparam logic [6:0] CMD_ERASE_PAGE = 7'h2B;
    localparam logic [6:0] CMD_WRITE_PAGE = 7'h2E;
    localparam logic [6:0] CMD_CHECK      = 7'h78;

    localparam logic [2:0] SEL_SIG   = 3'd0;
    localparam logic [2:0] SEL_KEY   = 3'd1;
    localparam logic [2:0] SEL_CMD   = 3'd2;
    localparam logic [2:0] SEL_EXEC  = 3'd3;
    localparam logic [2:0] SEL_LOCK  = 3'd4;
    localparam logic [2:0] SEL_GUARD = 3'd5;

    localparam logic [7:0] SIGNATURE  = 8'h59;
    localparam logic [7:0] GUARD_CODE = 8'hA5;

    typedef enum logic [1:0] {SRC_NONE, SRC_EXEC, SRC_READ, SRC_WRITE} trig_src_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_LOAD, OP_ERASE_BUF, OP_ERASE_PAGE, OP_WRITE_PAGE, OP_CHIP, OP_CHECK
    } store_op_e;

    typedef struct packed {
        trig_src_e src;
        logic      guarded;
        logic      long_op;
        store_op_e op;
    } cmd_attr_t;

    function automatic cmd_attr_t decode_cmd(input logic [6:0] code);
        cmd_attr_t a;
        a = '{src: SRC_NONE, guarded: 1'b0, long_op: 1'b0, op: OP_NONE};
        case (code)
            CMD_CHIP_ERASE: a = '{src: SRC_EXEC,  guarded: 1'b1, long_op: 1'b1, op: OP_CHIP};
            CMD_READ:       a = '{src: SRC_READ,  guarded: 1'b0, long_op: 1'b0, op: OP_NONE};
            CMD_LOAD_BUF:   a = '{src: SRC_WRITE, guarded: 1'b0, long_op: 1'b0, op: OP_LOAD};
            CMD_ERASE_BUF:  a = '{src: SRC_EXEC,  guarded: 1'b1, long_op: 1'b1, op: OP_ERASE_BUF};
            CMD_ERASE_PAGE: a = '{src: SRC_WRITE, guarded: 1'b0, long_op: 1'b1, op: OP_ERASE_PAGE};
            CMD_WRITE_PAGE: a = '{src: SRC_WRITE, guarded: 1'b0, long_op: 1'b1, op: OP_WRITE_PAGE};
            CMD_CHECK:      a = '{src: SRC_EXEC,  guarded: 1'b0, long_op: 1'b1, op: OP_CHECK};
            default:        ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/nvmprog_unlock.sv
module nvmprog_unlock
    import nvmprog_pkg::*;
#(
    parameter logic [7:0] KEY = 8'hC3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    output logic       en
);

    typedef enum logic [1:0] {UL_CLOSED, UL_SIG_SEEN, UL_OPEN} ul_state_e;

    ul_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_CLOSED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr && sel == SEL_SIG) begin
            if (wdata != SIGNATURE)       state_d = UL_CLOSED;
            else if (state_q != UL_OPEN)  state_d = UL_SIG_SEEN;
        end else if (wr && sel == SEL_KEY) begin
            unique case (state_q)
                UL_SIG_SEEN: state_d = (wdata == KEY) ? UL_OPEN : UL_CLOSED;
                UL_CLOSED:   state_d = UL_CLOSED;
                UL_OPEN:     state_d = UL_OPEN;
            endcase
        end
    end

    always_comb begin
        en = (state_q == UL_OPEN);
    end

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> $past(wr && sel == SEL_KEY && wdata == KEY)); // R2

    AST_BAD_SIG_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_SIG && wdata != SIGNATURE) |=> !en); // R2

endmodule

// File: rtl/nvmprog_store.sv
module nvmprog_store
    import nvmprog_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int PAGES      = 4,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = $clog2(PAGES),
    localparam int AW        = OFS_W + PG_W,
    localparam int DEPTH     = PAGE_BYTES * PAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  store_op_e     op,
    input  logic [AW-1:0] op_addr,
    input  logic [7:0]    op_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [OFS_W-1:0] op_ofs;
    logic [PG_W-1:0]  op_page;
    logic [PAGE_BYTES-1:0][7:0] buf_flat;
    logic [DEPTH-1:0][7:0]      arr_flat;

    assign op_ofs  = op_addr[OFS_W-1:0];
    assign op_page = op_addr[AW-1:OFS_W];

    for (genvar gj = 0; gj < PAGE_BYTES; gj++) begin : g_buf
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                      slot_q <= 8'hFF;
            else if (op == OP_CHIP || op == OP_ERASE_BUF)    slot_q <= 8'hFF;
            else if (op == OP_LOAD && int'(op_ofs) == gj)    slot_q <= op_data;
        end
        assign buf_flat[gj] = slot_q;
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        localparam int CELL_PG = gi / PAGE_BYTES;
        localparam int CELL_OF = gi % PAGE_BYTES;
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                                  cell_q <= 8'hFF;
            else if (op == OP_CHIP)                                      cell_q <= 8'hFF;
            else if (op == OP_ERASE_PAGE && int'(op_page) == CELL_PG)    cell_q <= 8'hFF;
            else if (op == OP_WRITE_PAGE && int'(op_page) == CELL_PG)    cell_q <= buf_flat[CELL_OF];
        end
        assign arr_flat[gi] = cell_q;
    end

    assign rd_byte = arr_flat[rd_addr];

    AST_CHIP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CHIP) |=> (rd_byte == 8'hFF)); // R12

endmodule

// File: rtl/nvmprog_ctrl.sv
module nvmprog_ctrl
    import nvmprog_pkg::*;
#(
    parameter int         PAGE_BYTES  = 8,
    parameter int         PAGES       = 4,
    parameter int         BUSY_CYCLES = 8,
    parameter logic [7:0] KEY         = 8'hC3,
    localparam int        ADDR_W      = $clog2(PAGE_BYTES) + $clog2(PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [2:0]        ctl_sel,
    input  logic [7:0]        ctl_wdata,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    output logic              nvm_en,
    output logic              busy,
    output logic [1:0]        lock_bits,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rd_blocked
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_CYCLES - 1);

    typedef enum logic {ST_IDLE, ST_BUSY} ctl_state_e;

    ctl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [6:0]        cmd_q;
    logic              arm_q;
    logic [1:0]        lock_q;
    store_op_e         run_op_q;
    logic [ADDR_W-1:0] run_addr_q;
    cmd_attr_t         attr;
    logic              finish, ctl_acc, cmd_ok, can_launch;
    logic              exec_go, wr_go, rd_go, launch;
    store_op_e         st_op;
    logic [ADDR_W-1:0] st_addr;
    logic [7:0]        st_rd_byte;

    nvmprog_unlock #(.KEY(KEY)) i_unlock (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (ctl_wr),
        .sel  (ctl_sel),
        .wdata(ctl_wdata),
        .en   (nvm_en)
    );

    nvmprog_store #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (st_op),
        .op_addr(st_addr),
        .op_data(mem_wdata),
        .rd_addr(mem_addr),
        .rd_byte(st_rd_byte)
    );

    // launch filtering
    assign attr       = decode_cmd(cmd_q);
    assign ctl_acc    = ctl_wr && nvm_en;
    assign cmd_ok     = !(&lock_q) || cmd_q == CMD_CHIP_ERASE || cmd_q == CMD_CHECK;
    assign can_launch = nvm_en && (state_q == ST_IDLE) && cmd_ok;
    assign exec_go    = can_launch && ctl_acc && ctl_sel == SEL_EXEC && ctl_wdata[0]
                        && attr.src == SRC_EXEC && (!attr.guarded || arm_q);
    assign wr_go      = can_launch && mem_wr && attr.src == SRC_WRITE;
    assign rd_go      = can_launch && mem_rd && attr.src == SRC_READ;
    assign launch     = exec_go || wr_go;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch && attr.long_op) state_d = ST_BUSY;
            ST_BUSY: if (finish)                 state_d = ST_IDLE;
        endcase
    end

    // FSM outputs
    always_comb begin
        busy   = (state_q == ST_BUSY);
        finish = (state_q == ST_BUSY) && (cnt_q == CNT_LAST);
        if (finish) begin
            st_op   = run_op_q;
            st_addr = run_addr_q;
        end else begin
            st_op   = (launch && !attr.long_op) ? attr.op : OP_NONE;
            st_addr = mem_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            run_op_q   <= OP_NONE;
            run_addr_q <= '0;
        end else begin
            cnt_q <= (state_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
            if (launch && attr.long_op) begin
                run_op_q   <= attr.op;
                run_addr_q <= mem_addr;
            end
        end
    end

    // command, guard and lock registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            arm_q  <= 1'b0;
            lock_q <= 2'b00;
        end else begin
            if (ctl_acc && ctl_sel == SEL_CMD) cmd_q <= ctl_wdata[6:0];
            if (!nvm_en)      arm_q <= 1'b0;
            else if (ctl_wr)  arm_q <= (ctl_sel == SEL_GUARD) && (ctl_wdata == GUARD_CODE);
            if (finish && run_op_q == OP_CHIP)
                lock_q <= 2'b00;
            else if (ctl_acc && ctl_sel == SEL_LOCK && state_q == ST_IDLE)
                lock_q <= lock_q | ctl_wdata[1:0];
        end
    end

    assign lock_bits = lock_q;

    // read response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= 8'hFF;
            rd_blocked <= 1'b0;
        end else begin
            rd_valid   <= mem_rd;
            rd_data    <= rd_go ? st_rd_byte : 8'hFF;
            rd_blocked <= !rd_go;
        end
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> rd_valid); // R4

    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> !rd_valid); // R4

    AST_BUSY_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && busy) |=> (rd_blocked && rd_data == 8'hFF)); // R8

    AST_CLOSED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!nvm_en && !busy) |=> !busy); // R3

    AST_FULL_LOCK_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && $past(lock_bits) == 2'b11)
            |-> ($past(cmd_q) == CMD_CHIP_ERASE || $past(cmd_q) == CMD_CHECK)); // R11

    AST_CHIP_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && run_op_q == OP_CHIP) |=> (lock_bits == 2'b00)); // R12

endmodule

// File: tb/test_nvmprog_ctrl.sv
`timescale 1ns/1ps
module test_nvmprog_ctrl;

    localparam int         PB  = 8;
    localparam int         NP  = 4;
    localparam int         BC  = 8;
    localparam logic [7:0] KY  = 8'hC3;
    localparam int         AW  = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [2:0]    ctl_sel = '0;
    logic [7:0]    ctl_wdata = '0;
    logic          mem_rd = 1'b0;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [7:0]    mem_wdata = '0;
    logic          nvm_en, busy, rd_valid, rd_blocked;
    logic [1:0]    lock_bits;
    logic [7:0]    rd_data;

    always #4 clk = ~clk;

    nvmprog_ctrl #(.PAGE_BYTES(PB), .PAGES(NP), .BUSY_CYCLES(BC), .KEY(KY)) i_nvmprog_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .nvm_en(nvm_en), .busy(busy), .lock_bits(lock_bits), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_blocked(rd_blocked)
    );

    typedef struct {
        logic [7:0] data;
        logic       blk;
        string      req;
    } rd_exp_t;

    rd_exp_t exp_q[$];
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item for each response
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "response with nothing expected", 1, 0);
            end else begin
                rd_exp_t e;
                e = exp_q.pop_front();
                check(rd_data == e.data, e.req, "read data", int'(rd_data), int'(e.data));
                check(rd_blocked == e.blk, e.req, "read blocked flag", int'(rd_blocked), int'(e.blk));
            end
        end
    end

    task automatic ctl_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_sel = s; ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic mem_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    // driver: pushes the expected response, then issues the read
    task automatic do_read(input logic [AW-1:0] a, input logic [7:0] d,
                           input logic blk, input string req);
        rd_exp_t e;
        e.data = d; e.blk = blk; e.req = req;
        @(negedge clk);
        exp_q.push_back(e);
        mem_rd = 1'b1; mem_addr = a;
        @(negedge clk);
        mem_rd = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy && cycles < 1000) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic set_cmd(input logic [6:0] c);
        ctl_write(3'd2, {1'b0, c});
    endtask

    task automatic guarded_exec();
        ctl_write(3'd5, 8'hA5);
        ctl_write(3'd3, 8'h01);
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog expired: actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(nvm_en == 1'b0, "R1", "nvm_en after reset", int'(nvm_en), 0);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(lock_bits == 2'b00, "R1", "lock_bits after reset", int'(lock_bits), 0);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);

        // R3 closed interface ignores command writes and blocks reads
        set_cmd(7'h43);
        do_read(5'd3, 8'hFF, 1'b1, "R3");

        // R2 unlock handshake
        ctl_write(3'd0, 8'h58);
        ctl_write(3'd1, KY);
        check(nvm_en == 1'b0, "R2", "bad signature then key", int'(nvm_en), 0);
        ctl_write(3'd0, 8'h59);
        check(nvm_en == 1'b0, "R2", "signature alone", int'(nvm_en), 0);
        ctl_write(3'd1, 8'h3C);
        ctl_write(3'd1, KY);
        check(nvm_en == 1'b0, "R2", "wrong key then right key", int'(nvm_en), 0);
        ctl_write(3'd0, 8'h59);
        ctl_write(3'd1, KY);
        check(nvm_en == 1'b1, "R2", "signature then key", int'(nvm_en), 1);

        // R3 command written while closed was dropped (command still 0x00)
        do_read(5'd3, 8'hFF, 1'b1, "R3");

        // R4 plain read of an erased array
        set_cmd(7'h43);
        do_read(5'd3, 8'hFF, 1'b0, "R4");

        // R5 buffer loads use only the low address bits
        set_cmd(7'h23);
        mem_write(5'h0A, 8'h11);
        mem_write(5'h0F, 8'h22);
        mem_write(5'h12, 8'h33);
        check(busy == 1'b0, "R5", "load starts no busy", int'(busy), 0);

        // R6 write page 1, R8 trigger and read refused while busy
        set_cmd(7'h2E);
        mem_write(5'h08, 8'h00);
        check(busy == 1'b1, "R7", "busy after write-page trigger", int'(busy), 1);
        mem_write(5'h10, 8'h00);
        set_cmd(7'h43);
        do_read(5'h0A, 8'hFF, 1'b1, "R8");
        wait_idle(cyc);
        do_read(5'h0A, 8'h33, 1'b0, "R6");
        do_read(5'h0F, 8'h22, 1'b0, "R6");
        do_read(5'h08, 8'hFF, 1'b0, "R6");
        do_read(5'h12, 8'hFF, 1'b0, "R8");

        // R7 busy length, R6 erase page
        set_cmd(7'h2B);
        mem_write(5'h0C, 8'h00);
        wait_idle(cyc);
        check(cyc == BC, "R7", "busy cycles", cyc, BC);
        set_cmd(7'h43);
        do_read(5'h0A, 8'hFF, 1'b0, "R6");

        // copy buffer into page 2
        set_cmd(7'h2E);
        mem_write(5'h10, 8'h00);
        wait_idle(cyc);
        set_cmd(7'h43);
        do_read(5'h12, 8'h33, 1'b0, "R6");

        // R9 execute with non-execute command or bit 0 clear
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b0, "R9", "execute with read command", int'(busy), 0);
        set_cmd(7'h78);
        ctl_write(3'd3, 8'h00);
        check(busy == 1'b0, "R9", "execute bit clear", int'(busy), 0);

        // R10 guard required, disarmed by another control write
        set_cmd(7'h26);
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b0, "R10", "guarded without arm", int'(busy), 0);
        ctl_write(3'd5, 8'hA5);
        set_cmd(7'h26);
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b0, "R10", "arm consumed by other write", int'(busy), 0);
        guarded_exec();
        check(busy == 1'b1, "R10", "guarded with arm", int'(busy), 1);
        wait_idle(cyc);

        // R13 erased buffer written to page 2
        set_cmd(7'h2E);
        mem_write(5'h10, 8'h00);
        wait_idle(cyc);
        set_cmd(7'h43);
        do_read(5'h12, 8'hFF, 1'b0, "R13");

        // R14 check stub leaves array unchanged
        set_cmd(7'h23);
        mem_write(5'h05, 8'h5A);
        set_cmd(7'h2E);
        mem_write(5'h00, 8'h00);
        wait_idle(cyc);
        set_cmd(7'h78);
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b1, "R14", "check stub busy", int'(busy), 1);
        wait_idle(cyc);
        set_cmd(7'h43);
        do_read(5'h05, 8'h5A, 1'b0, "R14");

        // R11 locks
        ctl_write(3'd4, 8'h01);
        check(lock_bits == 2'b01, "R11", "read lock only", int'(lock_bits), 1);
        do_read(5'h05, 8'h5A, 1'b0, "R11");
        ctl_write(3'd4, 8'h02);
        check(lock_bits == 2'b11, "R11", "both locks", int'(lock_bits), 3);
        do_read(5'h05, 8'hFF, 1'b1, "R11");
        set_cmd(7'h2B);
        mem_write(5'h00, 8'h00);
        check(busy == 1'b0, "R11", "erase page under full lock", int'(busy), 0);
        set_cmd(7'h78);
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b1, "R11", "check stub under full lock", int'(busy), 1);
        wait_idle(cyc);

        // R12 chip erase
        set_cmd(7'h40);
        ctl_write(3'd3, 8'h01);
        check(busy == 1'b0, "R10", "chip erase without arm", int'(busy), 0);
        guarded_exec();
        check(busy == 1'b1, "R12", "chip erase under full lock", int'(busy), 1);
        wait_idle(cyc);
        check(lock_bits == 2'b00, "R12", "locks cleared", int'(lock_bits), 0);
        set_cmd(7'h43);
        do_read(5'h05, 8'hFF, 1'b0, "R12");
        set_cmd(7'h2E);
        mem_write(5'h08, 8'h00);
        wait_idle(cyc);
        set_cmd(7'h43);
        do_read(5'h0F, 8'hFF, 1'b0, "R12");

        // R2 non-signature write closes the interface
        ctl_write(3'd0, 8'h00);
        check(nvm_en == 1'b0, "R2", "closed by non-signature", int'(nvm_en), 0);
        do_read(5'h05, 8'hFF, 1'b1, "R3");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule